// File: doc/BRIEF.md
# Serial Host Register Access Port

This block is a slave serial port through which an external host reads and writes a file of 32 byte-wide registers. The host lowers an active-low chip-select, then clocks a 16-bit frame on a serial clock. The first byte of the frame is a command byte and the second byte is a data byte. The block samples its input line on rising serial-clock edges and changes its output line on falling edges. All three input pins pass through two-flop synchronizers into the system clock domain.

Command byte layout, with bits sent least-significant first: bit 0 is the direction flag (1 = read, 0 = write), bits 1 to 5 are the register address, and bits 6 and 7 are ignored. On a write, the data byte comes in on the input line and is stored when its sixteenth bit arrives. On a read, the block shifts the addressed register out on the output line during the data byte, least-significant bit first, and ignores the input line. An output-enable marks when the output line is actively driven. Outside that window the output line is treated as high-impedance.

Top module: `sreg_port`

## Requirements
- R1: After reset every register reads back as 0x00 and the output-enable is low.
- R2: A write frame (bit 0 = 0, address in bits 1 to 5, both bytes sent least-significant first) stores the data byte. A later read frame (bit 0 = 1) to the same address returns that byte on the output line, least-significant bit first, during bits 8 to 15.
- R3: Command bits 6 and 7 have no effect. Addresses that differ only in those bits reach the same register for both reads and writes.
- R4: During a read frame the input line is ignored while the data byte is sent, and the read leaves the register unchanged.
- R5: If chip-select rises before the sixteenth rising serial-clock edge, the frame is abandoned and no register changes.
- R6: The output-enable is high only during the data byte of a read frame. It is low throughout write frames and while chip-select is high.
- R7: Serial-clock edges after the sixteenth bit of a frame are ignored until chip-select rises. They cause no second write and change no other register.
- R8: The output line changes only after a falling serial-clock edge while the port is selected, so read data is stable when the host samples it at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select; must stay low for a whole frame |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host, sampled on rising sck |
| sdo | output | 1 | Serial data to the host, updated after falling sck |
| sdo_oe | output | 1 | High while sdo carries read data |

## Verification
A wrong bit counter or wrong phase state shows at the ports within one frame. Read data comes back shifted or from the wrong register, or a write reaches the register file on an aborted or over-long frame, and the next read frame exposes it. A wrong address decode or an aliasing fault is caught by writing through one address form and reading back through another. A stuck output-enable shows in the middle of the very next frame: it is sampled during the data byte of every frame and again after every deselect.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    parameter int unsigned ADDR_W  = 5;
    parameter int unsigned IGN_W   = 2;
    parameter int unsigned CMD_W   = 1 + ADDR_W + IGN_W;
    parameter int unsigned DATA_W  = 8;
    parameter int unsigned NREG    = 1 << ADDR_W;
    parameter int unsigned SR_W    = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    parameter int unsigned CNT_W   = $clog2(SR_W);
    parameter int unsigned SYNC_ST = 2;

    typedef struct packed {
        logic [IGN_W-1:0]  ignored;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic cmd_t to_cmd(input logic [SR_W-1:0] sr);
        return cmd_t'(sr[SR_W-1 -: CMD_W]);
    endfunction

    function automatic logic [CNT_W-1:0] last_idx(input int unsigned nbits);
        return CNT_W'(nbits - 1);
    endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        logic [W-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= g_stg[s-1].q;
            end
        end
    end
    assign dout = g_stg[STAGES-1].q;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic              sck_fall,
    output logic              rd_load,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_end,
    output wr_req_t           wr_req
);
    logic             sck_d;
    logic             sck_rise;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [SR_W-1:0]  sr;
    logic [SR_W-1:0]  sr_next;
    cmd_t             cmd_q;
    cmd_t             cmd_now;
    logic             in_cmd;
    logic             cmd_last;
    logic             data_last;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign sck_rise  = sck_s & ~sck_d & ~cs_s;
    assign sck_fall  = ~sck_s & sck_d & ~cs_s;
    assign sr_next   = {sdi_s, sr[SR_W-1:1]};
    assign cmd_now   = to_cmd(sr_next);
    assign in_cmd    = (phase == PH_IDLE) || (phase == PH_CMD);
    assign cmd_last  = in_cmd && (cnt == last_idx(CMD_W));
    assign data_last = (phase == PH_DATA) && (cnt == last_idx(DATA_W));

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sr    <= '0;
            cmd_q <= '0;
        end else if (sck_rise) begin
            unique case (phase)
                PH_IDLE, PH_CMD: begin
                    sr <= sr_next;
                    if (cmd_last) begin
                        cmd_q <= cmd_now;
                        cnt   <= '0;
                        phase <= PH_DATA;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        phase <= PH_CMD;
                    end
                end
                PH_DATA: begin
                    sr <= sr_next;
                    if (data_last) begin
                        cnt   <= '0;
                        phase <= PH_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_DONE;
                end
            endcase
        end
    end

    assign rd_load = sck_rise && cmd_last && cmd_now.rd;
    assign rd_addr = cmd_now.addr;
    assign rd_end  = sck_rise && data_last && cmd_q.rd;

    always_comb begin
        wr_req.en   = sck_rise && data_last && !cmd_q.rd;
        wr_req.addr = cmd_q.addr;
        wr_req.data = sr_next[SR_W-1 -: DATA_W];
    end
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREG); i++) mem[i] <= '0;
        end else if (wr_req.en) begin
            mem[wr_req.addr] <= wr_req.data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sreg_txshift.sv
module sreg_txshift
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_fall,
    input  logic              stop,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [DATA_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            sr     <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else begin
            if (load) begin
                sr     <= load_data;
                sdo_oe <= 1'b1;
            end else if (sck_fall && sdo_oe) begin
                sdo <= sr[0];
                sr  <= {1'b0, sr[DATA_W-1:1]};
            end
            if (stop) sdo_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic [2:0]        pins_s;
    logic              cs_s;
    logic              sck_s;
    logic              sdi_s;
    logic              sck_fall;
    logic              rd_load;
    logic              rd_end;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    wr_req_t           wr_req;
    logic              wr_en;

    sreg_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({cs_n, sck, sdi}),
        .dout(pins_s)
    );
    assign {cs_s, sck_s, sdi_s} = pins_s;

    sreg_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (cs_s),
        .sck_s   (sck_s),
        .sdi_s   (sdi_s),
        .sck_fall(sck_fall),
        .rd_load (rd_load),
        .rd_addr (rd_addr),
        .rd_end  (rd_end),
        .wr_req  (wr_req)
    );

    sreg_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    sreg_txshift u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_s     (cs_s),
        .load     (rd_load),
        .load_data(rd_data),
        .sck_fall (sck_fall),
        .stop     (rd_end),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    assign wr_en = wr_req.en;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk (
    input logic clk,
    input logic rst,
    input logic cs_s,
    input logic sck_fall,
    input logic wr_en,
    input logic sdo,
    input logic sdo_oe
);
    assert_oe_off_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !sdo_oe);

    assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !sdo_oe);

    assert_sdo_fall_only_R8: assert property (@(posedge clk) disable iff (rst)
        (!sck_fall && !cs_s) |=> $stable(sdo));

    assert_write_selected_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!cs_s && $past(!cs_s)));
endmodule

bind sreg_port sreg_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (cs_s),
    .sck_fall(sck_fall),
    .wr_en   (wr_en),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
);

// File: tb/sim_sreg_port.sv
`timescale 1ns/1ps
module sim_sreg_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;

    always #2.5 clk = ~clk;

    sreg_port u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit [7:0] model [32];
    bit [7:0] act_q [$];
    bit [7:0] exp_val [$];
    string    exp_tag [$];

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit [7:0] act, input bit [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame(input bit rw, input bit [4:0] a, input bit [1:0] hi,
                         input bit [7:0] d, input int nbits, input string tag);
        bit [7:0] cmd;
        bit [7:0] got;
        cmd = {hi, a, rw};
        got = '0;
        cs_n = 1'b0;
        step(8);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? cmd[i] : ((i < 16) ? d[i-8] : 1'b1);
            step(8);
            if (rw && i >= 8 && i < 16) got[i-8] = sdo;
            if (i == 10) chk({7'd0, sdo_oe}, {7'd0, rw}, {tag, " R6 oe mid data"});
            sck = 1'b1;
            step(8);
            sck = 1'b0;
        end
        step(8);
        cs_n = 1'b1;
        step(8);
        chk({7'd0, sdo_oe}, 8'd0, {tag, " R6 oe after deselect"});
        if (rw && nbits >= 16) act_q.push_back(got);
    endtask

    task automatic wr(input bit [4:0] a, input bit [1:0] hi, input bit [7:0] d,
                      input int nbits, input string tag);
        frame(1'b0, a, hi, d, nbits, tag);
        if (nbits >= 16) model[a] = d;
    endtask

    task automatic rd(input bit [4:0] a, input bit [1:0] hi, input bit [7:0] fill,
                      input string tag);
        exp_val.push_back(model[a]);
        exp_tag.push_back(tag);
        frame(1'b1, a, hi, fill, 16, tag);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_val.size() > 0) begin
                bit [7:0] v;
                bit [7:0] e;
                string t;
                v = act_q.pop_front();
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                chk(v, e, t);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        step(10);
        rst = 1'b0;
        step(6);
        chk({7'd0, sdo_oe}, 8'd0, "R1 oe after reset");
        rd(5'd0,  2'd0, 8'h00, "R1 reset value addr 0");
        rd(5'd31, 2'd0, 8'h00, "R1 reset value addr 31");
        rd(5'd13, 2'd0, 8'h00, "R1 reset value addr 13");

        wr(5'd3,  2'd0, 8'hA5, 16, "R2 write 3");
        wr(5'd31, 2'd0, 8'h3C, 16, "R2 write 31");
        wr(5'd0,  2'd0, 8'hFF, 16, "R2 write 0");
        wr(5'd17, 2'd0, 8'h01, 16, "R2 write 17");
        rd(5'd3,  2'd0, 8'h00, "R2 R8 read 3");
        rd(5'd31, 2'd0, 8'h00, "R2 R8 read 31");
        rd(5'd0,  2'd0, 8'h00, "R2 R8 read 0");
        rd(5'd17, 2'd0, 8'h00, "R2 R8 read 17");
        rd(5'd1,  2'd0, 8'h00, "R2 untouched neighbour 1");

        wr(5'd5, 2'd3, 8'h5A, 16, "R3 write alias hi=3");
        rd(5'd5, 2'd0, 8'h00, "R3 read plain addr 5");
        wr(5'd9, 2'd0, 8'h77, 16, "R3 write plain addr 9");
        rd(5'd9, 2'd2, 8'h00, "R3 read alias hi=2");

        rd(5'd3, 2'd0, 8'hFF, "R4 read with sdi ones");
        rd(5'd3, 2'd0, 8'h00, "R4 read after read");

        wr(5'd3, 2'd0, 8'h00, 12, "R5 abort after 12 bits");
        wr(5'd3, 2'd0, 8'h00, 8,  "R5 abort after command");
        rd(5'd3, 2'd0, 8'h00, "R5 register kept");

        wr(5'd20, 2'd0, 8'hC3, 20, "R7 write with extra bits");
        rd(5'd20, 2'd0, 8'h00, "R7 read 20");
        rd(5'd21, 2'd0, 8'h00, "R7 neighbour 21 unchanged");
        rd(5'd31, 2'd0, 8'h00, "R7 addr 31 unchanged");

        step(20);
        chk(8'(exp_val.size()), 8'd0, "R2 scoreboard drained");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule